// File: doc/BRIEF.md
# Reset Extension and Link-Training Sequencer

This block produces the internal reset for a receive-side packet interface and then takes that interface through link training. An external active-low reset is filtered, so only a low period of at least a set number of reference-clock cycles counts. A group of monitored clocks is watched with toggle detectors that run off a free-running reference counter. The internal reset is held for as long as the external reset is held or any monitored clock is absent. After both conditions clear, the reset stays asserted for a further long, fixed number of reference cycles. If a clock disappears, or arrives late, the reset is applied again and the full count starts over.

When the internal reset is released, the receive interface sends a fixed training word on every cycle. A one-cycle calendar-valid pulse, already qualified in the reference domain, moves it into the synchronised state and raises a status bit. In the synchronised state a data word is launched only when the upstream side offers data and the 2-bit far-end status bus grants a credit. On every other synchronised cycle the bus is idle. A loss code on the status bus sends the interface back to training.

Top module: `rst_train_seq`

## Requirements
- R1: A low pulse on `ext_rst_n` that lasts fewer than MIN_LOW reference cycles after synchronisation has no effect: `int_rst_n`, `rx_train` and `sync_ok` keep their values.
- R2: A low period of at least MIN_LOW cycles drives `int_rst_n` low. It stays low while the external reset is held, and for at least EXT_CYC cycles after it is released.
- R3: `int_rst_n` rises only after every monitored clock has been seen toggling (at least MIN_EDGES edges in a WIN-cycle window) and has stayed present for EXT_CYC consecutive cycles.
- R4: A monitored clock that stops toggling for a full window drives `int_rst_n` low. When the clock later starts again, including after the external reset has been released, the full EXT_CYC count restarts from that point.
- R5: After internal reset release, and before the first calendar-valid pulse, the block behaves as follows: `rx_train`=1, `rx_data`=TRAIN_PAT, `rx_launch`=0 and `sync_ok`=0. This holds even while data and a credit are offered.
- R6: A `cal_valid` pulse sampled while training sets `sync_ok`=1 and `rx_train`=0 from the next cycle.
- R7: While synchronised, `rx_launch`=1 and `rx_data`=`data_in` exactly when `data_avail`=1 and the synchronised `far_stat` equals 2'b01 (credit). Codes 2'b00 and 2'b10 grant no credit, and the bus then carries 0. `far_stat` passes through two flops, so a change is used from the second reference edge after it.
- R8: While synchronised, `far_stat`=2'b11 (calendar lost) returns the block to training. `sync_ok` clears on the third reference edge after the code is applied.
- R9: While `int_rst_n` is low, `rx_train`, `sync_ok` and `rx_launch` are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| ext_rst_n | input | 1 | External active-low reset, asynchronous |
| mon_clk | input | NCLK | Monitored clocks, sampled for toggling |
| cal_valid | input | 1 | Qualified one-cycle calendar-valid pulse |
| far_stat | input | 2 | Far-end status code, asynchronous |
| data_avail | input | 1 | Upstream has a word ready |
| data_in | input | DW | Word to launch |
| int_rst_n | output | 1 | Extended internal active-low reset |
| rx_train | output | 1 | Training word being sent |
| rx_data | output | DW | Training word, launched data or 0 |
| rx_launch | output | 1 | Data word launched this cycle |
| sync_ok | output | 1 | Synchronised status bit |

## Verification
The reset path is exercised in three ways:
- A long power-up reset with both clocks running checks the lower bound of the extension.
- A short pulse below the filter length must change nothing.
- A monitored clock is stopped, restarted part-way through the count, stopped again and restarted after an external reset. This separates a counter that resumes from one that restarts in full.

The interface side is exercised in three ways:
- Data and credit are offered during training, and no launch may appear before the calendar pulse.
- Once synchronised, alternating and bursty availability under credit is compared word by word through a scoreboard.
- The no-credit codes and the loss code separate credit gating from the return to training.

// File: rtl/rst_train_seq.sv
module rst_train_seq #(
  parameter int NCLK      = 2,
  parameter int DW        = 32,
  parameter int MIN_LOW   = 25,
  parameter int WIN       = 64,
  parameter int MIN_EDGES = 8,
  parameter int EXT_CYC   = 1027500,
  parameter logic [DW-1:0] TRAIN_PAT = 32'h0F0F_F0F0
) (
  input  logic            clk,
  input  logic            ext_rst_n,
  input  logic [NCLK-1:0] mon_clk,
  input  logic            cal_valid,
  input  logic [1:0]      far_stat,
  input  logic            data_avail,
  input  logic [DW-1:0]   data_in,
  output logic            int_rst_n,
  output logic            rx_train,
  output logic [DW-1:0]   rx_data,
  output logic            rx_launch,
  output logic            sync_ok
);
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam int WW = $clog2(WIN);
  localparam int EW = $clog2(MIN_EDGES + 1);
  localparam int XW = $clog2(EXT_CYC + 1);
  localparam logic [LW-1:0] LTHR  = LW'(MIN_LOW - 1);
  localparam logic [WW-1:0] WLAST = WW'(WIN - 1);
  localparam logic [EW-1:0] EMAX  = EW'(MIN_EDGES);
  localparam logic [EW-1:0] EPRE  = EW'(MIN_EDGES - 1);
  localparam logic [XW-1:0] XLAST = XW'(EXT_CYC - 1);

  typedef enum logic {ST_TRAIN, ST_SYNC} st_t;

  logic          ext_q1 = 1'b0, ext_q2 = 1'b0;
  logic [LW-1:0] lowcnt = '0;
  logic          rst_hold = 1'b1;

  always_ff @(posedge clk) begin
    ext_q1 <= ext_rst_n;
    ext_q2 <= ext_q1;
    if (ext_q2) lowcnt <= '0;
    else if (lowcnt != LTHR) lowcnt <= lowcnt + 1'b1;
    if (ext_q2) rst_hold <= 1'b0;
    else if (lowcnt == LTHR) rst_hold <= 1'b1;
  end

  logic [WW-1:0]   wcnt = '0;
  logic [NCLK-1:0] c1 = '0, c2 = '0, c3 = '0;
  logic [NCLK-1:0] present = '0;
  logic            win_end;
  logic            all_ok;

  assign win_end = (wcnt == WLAST);
  assign all_ok  = &present;

  always_ff @(posedge clk) begin
    wcnt <= win_end ? '0 : wcnt + 1'b1;
    c1 <= mon_clk;
    c2 <= c1;
    c3 <= c2;
  end

  for (genvar i = 0; i < NCLK; i++) begin : g_mon
    logic [EW-1:0] ecnt = '0;
    logic          edge_i;
    assign edge_i = c2[i] ^ c3[i];
    always_ff @(posedge clk) begin
      if (win_end) begin
        present[i] <= (ecnt == EMAX) || (edge_i && ecnt == EPRE);
        ecnt <= '0;
      end else if (edge_i && ecnt != EMAX) begin
        ecnt <= ecnt + 1'b1;
      end
    end
  end

  logic [XW-1:0] xcnt = '0;
  logic          irst_q = 1'b0;
  assign int_rst_n = irst_q;

  always_ff @(posedge clk) begin
    if (rst_hold || !all_ok) begin
      xcnt   <= '0;
      irst_q <= 1'b0;
    end else if (!irst_q) begin
      if (xcnt == XLAST) irst_q <= 1'b1;
      else xcnt <= xcnt + 1'b1;
    end
  end

  logic [1:0] stat_q1 = 2'b00, stat_q2 = 2'b00;
  st_t        st = ST_TRAIN;
  logic       credit;

  always_ff @(posedge clk) begin
    stat_q1 <= far_stat;
    stat_q2 <= stat_q1;
    if (!irst_q) st <= ST_TRAIN;
    else if (st == ST_TRAIN && cal_valid) st <= ST_SYNC;
    else if (st == ST_SYNC && stat_q2 == 2'b11) st <= ST_TRAIN;
  end

  assign credit    = (stat_q2 == 2'b01);
  assign rx_train  = irst_q && (st == ST_TRAIN);
  assign sync_ok   = irst_q && (st == ST_SYNC);
  assign rx_launch = sync_ok && data_avail && credit;
  assign rx_data   = rx_launch ? data_in : (rx_train ? TRAIN_PAT : '0);
endmodule

// File: rtl/rst_train_seq_chk.sv
module rst_train_seq_chk (
  input logic       clk,
  input logic       int_rst_n,
  input logic       rx_train,
  input logic       sync_ok,
  input logic       rx_launch,
  input logic       cal_valid,
  input logic       data_avail,
  input logic [1:0] stat_q2,
  input logic       all_ok,
  input logic       rst_hold
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  a_r2_hold_reset: assert property (@(posedge clk) disable iff (!armed)
    rst_hold |=> !int_rst_n);

  a_r3_release_when_stable: assert property (@(posedge clk) disable iff (!armed)
    (int_rst_n && !$past(int_rst_n)) |-> ($past(all_ok) && !$past(rst_hold)));

  a_r4_clock_loss: assert property (@(posedge clk) disable iff (!armed)
    !all_ok |=> !int_rst_n);

  a_r5_no_early_launch: assert property (@(posedge clk) disable iff (!armed)
    rx_train |-> !rx_launch);

  a_r6_enter_sync: assert property (@(posedge clk) disable iff (!armed)
    (rx_train && cal_valid) |=> (sync_ok || !int_rst_n));

  a_r7_launch_needs_credit: assert property (@(posedge clk) disable iff (!armed)
    rx_launch |-> (data_avail && stat_q2 == 2'b01));

  a_r8_calendar_loss: assert property (@(posedge clk) disable iff (!armed)
    (sync_ok && stat_q2 == 2'b11) |=> !sync_ok);

  a_r9_quiet_in_reset: assert property (@(posedge clk) disable iff (!armed)
    !int_rst_n |-> (!rx_train && !sync_ok && !rx_launch));
endmodule

bind rst_train_seq rst_train_seq_chk u_chk (.*);

// File: tb/rst_train_seq_tb.sv
`timescale 1ns/1ps
module rst_train_seq_tb;
  localparam int NCLK = 2, DW = 16, MIN_LOW = 25, WIN = 32, MIN_EDGES = 4, EXT_CYC = 200;
  localparam logic [DW-1:0] PAT = 16'hA5C3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            ext_rst_n = 1'b0;
  logic [NCLK-1:0] mon_clk = '0, en = '1;
  logic            cal_valid = 1'b0;
  logic [1:0]      far_stat = 2'b00;
  logic            data_avail = 1'b0;
  logic [DW-1:0]   data_in = '0;
  logic            int_rst_n, rx_train, rx_launch, sync_ok;
  logic [DW-1:0]   rx_data;

  rst_train_seq #(.NCLK(NCLK), .DW(DW), .MIN_LOW(MIN_LOW), .WIN(WIN),
                  .MIN_EDGES(MIN_EDGES), .EXT_CYC(EXT_CYC), .TRAIN_PAT(PAT)) u_dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .mon_clk(mon_clk), .cal_valid(cal_valid),
    .far_stat(far_stat), .data_avail(data_avail), .data_in(data_in),
    .int_rst_n(int_rst_n), .rx_train(rx_train), .rx_data(rx_data),
    .rx_launch(rx_launch), .sync_ok(sync_ok));

  initial begin
    #1.5;
    forever begin
      #7;
      for (int i = 0; i < NCLK; i++) if (en[i]) mon_clk[i] = ~mon_clk[i];
    end
  end

  int checks = 0, errors = 0;
  logic [DW-1:0] q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rx_launch) begin
        if (q.size() == 0) chk(0, "R5/R7", "unexpected launch", rx_data, 0);
        else begin
          logic [DW-1:0] e;
          e = q.pop_front();
          chk(rx_data == e, "R7", "launched word", rx_data, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (!int_rst_n && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic hold_low(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(int_rst_n == 1'b0, req, "int_rst_n held low", int_rst_n, 0);
    end
  endtask

  task automatic send(input logic [DW-1:0] w, input bit avail, input bit expect_launch);
    @(posedge clk); #1;
    data_avail = avail;
    data_in = w;
    if (expect_launch) q.push_back(w);
  endtask

  initial begin
    int n;
    tick(5);
    @(negedge clk);
    chk(int_rst_n == 0, "R9", "reset int_rst_n", int_rst_n, 0);
    chk(rx_train == 0 && sync_ok == 0 && rx_launch == 0, "R9", "reset outputs",
        {rx_train, sync_ok, rx_launch}, 0);
    chk(rx_data == 0, "R9", "reset rx_data", rx_data, 0);
    tick(35);
    ext_rst_n = 1'b1;
    wait_release(n);
    chk(n >= EXT_CYC, "R2", "extension after release", n, EXT_CYC);
    chk(n <= EXT_CYC + 3*WIN + 8, "R3", "release not late", n, EXT_CYC + 3*WIN + 8);

    far_stat = 2'b01; data_avail = 1'b1; data_in = 16'h1234;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(rx_train == 1 && rx_launch == 0 && sync_ok == 0, "R5", "training with data",
          {rx_train, rx_launch, sync_ok}, 4);
      chk(rx_data == PAT, "R5", "training word", rx_data, PAT);
    end

    tick(1); data_avail = 1'b0; cal_valid = 1'b1;
    @(posedge clk); #1; cal_valid = 1'b0;
    @(negedge clk);
    chk(sync_ok == 1 && rx_train == 0, "R6", "sync entry", {sync_ok, rx_train}, 2);
    chk(rx_data == 0, "R7", "idle in sync", rx_data, 0);

    for (int k = 0; k < 8; k++) send(16'h0100 + 16'(k), k % 2 == 0, k % 2 == 0);
    for (int k = 0; k < 6; k++) send(16'h0200 + 16'(k), 1'b1, 1'b1);
    send(0, 1'b0, 1'b0);

    @(posedge clk); #1; far_stat = 2'b00;
    tick(3);
    for (int k = 0; k < 5; k++) begin
      send(16'h0300 + 16'(k), 1'b1, 1'b0);
      @(negedge clk);
      chk(rx_launch == 0 && rx_data == 0, "R7", "no credit code 00", rx_launch, 0);
    end
    far_stat = 2'b10;
    tick(3);
    for (int k = 0; k < 5; k++) begin
      send(16'h0400 + 16'(k), 1'b1, 1'b0);
      @(negedge clk);
      chk(rx_launch == 0, "R7", "no credit code 10", rx_launch, 0);
    end
    data_avail = 1'b0;
    far_stat = 2'b01;
    tick(3);
    for (int k = 0; k < 4; k++) send(16'h0500 + 16'(k), 1'b1, 1'b1);
    send(0, 1'b0, 1'b0);
    tick(2);
    chk(q.size() == 0, "R7", "all expected words launched", q.size(), 0);

    @(posedge clk); #1; far_stat = 2'b11;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(sync_ok == 1, "R8", "still synced before loss lands", sync_ok, 1);
    @(posedge clk); @(negedge clk);
    chk(sync_ok == 0 && rx_train == 1, "R8", "back to training", {sync_ok, rx_train}, 1);
    far_stat = 2'b00;

    tick(1); ext_rst_n = 1'b0;
    tick(10); ext_rst_n = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(int_rst_n == 1 && rx_train == 1, "R1", "short pulse ignored", {int_rst_n, rx_train}, 3);
    end

    en[1] = 1'b0;
    n = 0;
    while (int_rst_n && n < 500) begin @(negedge clk); n++; end
    chk(int_rst_n == 0 && n <= 3*WIN + 8, "R4", "clock loss asserts reset", n, 3*WIN + 8);
    hold_low(100, "R4");
    tick(1); ext_rst_n = 1'b0;
    tick(30); ext_rst_n = 1'b1;
    hold_low(20, "R2");
    en[1] = 1'b1;
    hold_low(150, "R4");
    en[1] = 1'b0;
    hold_low(120, "R4");
    en[1] = 1'b1;
    wait_release(n);
    chk(n >= EXT_CYC, "R4", "full count after late clock", n, EXT_CYC);
    chk(n <= EXT_CYC + 3*WIN + 8, "R3", "late release bounded", n, EXT_CYC + 3*WIN + 8);
    @(negedge clk);
    chk(rx_train == 1 && sync_ok == 0, "R5", "training after re-reset", {rx_train, sync_ok}, 2);
    chk(rx_data == PAT, "R5", "training word after re-reset", rx_data, PAT);

    tick(2);
    summary();
    $finish;
  end
endmodule